// File: doc/BRIEF.md
# Serial Readback Output Engine

This block drives the data-out line of a register-mapped serial slave. It decides what is shifted out during each chip-select frame. A readback select register sets the policy and the register to read; it is loaded by accepted writes that the write-side logic hands over. The write-side logic checks, decodes and accepts each incoming frame, and it delivers a one-cycle accept pulse with the frame's register address and data between frames.

Each frame that the engine drives is 32 bits long. The frame carries a fixed two-bit sync marker, the fault pin level, a register address and a 16-bit data field, then an 8-bit CRC. There are four policies:
- Two-stage read: a select write is followed by a frame that carries the chosen register.
- Status every frame.
- Status gated by a flag that records a write to this device, so that several slaves can share one chip select.
- Echo: frames alternate between status and the last accepted command.

The serial clock and chip select reach the block as levels that are sampled on the system clock. Output data is launched on the serial-clock edge opposite the one the master samples on.

Top module: `rb_sdo_engine`

## Requirements
- R1: After reset the policy is two-stage read, the selected register is 0, and `sdo_oe` is low.
- R2: A driven frame is, MSB first: bits 31:30 = 2'b10, bit 29 = `fault_in` sampled at frame start, bits 28:24 = address, bits 23:8 = data, bits 7:0 = CRC-8 with polynomial x^8+x^2+x+1 (0x07), initial value 0, no reflection, computed over bits 31:8 MSB first. For example, address 0x14 holding 0xA000 with the fault level low gives 0x94A0001A.
- R3: With `crc_en` low the frame holds the 24-bit word in bits 31:8, so the sync marker sits at bits 23:22 of that word, and bits 7:0 are zero.
- R4: An accepted write to address 0x13 loads the selected register from data bits 4:0 and the policy from data bits 9:8 (00 two-stage, 01 status, 10 shared status, 11 echo).
- R5: In two-stage mode, the frame after a select write carries the selected register's address and contents from `rd_data`. A frame with no preceding select write is not driven.
- R6: A select write accepted between the read frame and the next frame makes the next frame carry the newly selected register (pipelined reads).
- R7: In status mode every frame carries address 0x15 and `status_word`.
- R8: In shared status mode a frame carries status only if at least one write was accepted since the previous frame start. Otherwise `sdo_oe` stays low for the whole frame.
- R9: In echo mode the first frame after the select write carries status. Frames then alternate, and every second frame carries the address and data of the most recently accepted write.
- R10: `sdo_oe` is low while `sync_n` is high. Bit 31 is valid before the first sampling (falling) edge of `sclk`, and each later bit appears on a rising edge.
- R11: `rd_addr` always presents the selected register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_n | input | 1 | Chip select, active low, sampled on `clk` |
| sclk | input | 1 | Serial clock level, sampled on `clk` |
| crc_en | input | 1 | Append CRC to output frames |
| fault_in | input | 1 | Fault pin level placed in bit 29 |
| status_word | input | 16 | Status register contents |
| wr_valid | input | 1 | One-cycle pulse: an accepted write for this device |
| wr_addr | input | 5 | Register address of the accepted write |
| wr_data | input | 16 | Data of the accepted write |
| rd_addr | output | 5 | Register file read address |
| rd_data | input | 16 | Register file contents at `rd_addr` |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for `sdo` (low = high impedance) |

## Verification
The bench builds the engine with its default parameters. These are a low-idle serial clock, select address 0x13, status address 0x15 and polynomial 0x07. With an idle-low clock the first rising edge of each frame must be skipped, so the skip path is the one exercised. One vector walk steps through all four policies in turn, using the same register and chip-select sequence. This covers the transitions between policies: a pending two-stage read that is consumed, the shared flag that is cleared by a frame with no write, and the echo phase that restarts when the policy is reselected. The worked frame value and a frame with CRC turned off are compared bit for bit.

// File: rtl/rb_pkg.sv
package rb_pkg;

    localparam int ADDR_W  = 5;
    localparam int DATA_W  = 16;
    localparam int CRC_W   = 8;
    localparam int HDR_W   = 3 + ADDR_W + DATA_W;
    localparam int FRAME_W = HDR_W + CRC_W;

    // bit positions inside the select register
    localparam int MODE_LSB = 8;

    typedef enum logic [1:0] {
        RB_TWO_STAGE = 2'b00,
        RB_STATUS    = 2'b01,
        RB_SHARED    = 2'b10,
        RB_ECHO      = 2'b11
    } rb_mode_e;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_REG,
        SRC_STATUS,
        SRC_ECHO
    } rb_src_e;

    typedef struct packed {
        logic              fault;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } rb_payload_t;

    function automatic logic [CRC_W-1:0] crc_calc(
        input logic [HDR_W-1:0] hdr,
        input logic [CRC_W-1:0] poly
    );
        logic [CRC_W-1:0] c;
        logic             fb;
        c = '0;
        for (int i = HDR_W - 1; i >= 0; i--) begin
            fb = c[CRC_W-1] ^ hdr[i];
            c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
        end
        return c;
    endfunction

    function automatic logic [FRAME_W-1:0] build_frame(
        input rb_payload_t      p,
        input logic             crc_on,
        input logic [CRC_W-1:0] poly
    );
        logic [HDR_W-1:0] hdr;
        hdr = {2'b10, p};
        return {hdr, (crc_on ? crc_calc(hdr, poly) : {CRC_W{1'b0}})};
    endfunction

endpackage

// File: rtl/rb_select_regs.sv
module rb_select_regs
    import rb_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SEL_ADDR = 5'h13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              frame_start,
    output rb_mode_e          mode,
    output logic [ADDR_W-1:0] sel_reg,
    output logic              pending,
    output logic              shared_flag,
    output logic              echo_phase,
    output logic [ADDR_W-1:0] last_addr,
    output logic [DATA_W-1:0] last_data
);

    logic     sel_write;
    rb_mode_e new_mode;

    assign sel_write = wr_valid && (wr_addr == SEL_ADDR);
    assign new_mode  = rb_mode_e'(wr_data[MODE_LSB+1:MODE_LSB]);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode        <= RB_TWO_STAGE;
            sel_reg     <= '0;
            pending     <= 1'b0;
            shared_flag <= 1'b0;
            echo_phase  <= 1'b0;
            last_addr   <= '0;
            last_data   <= '0;
        end else begin
            if (frame_start) begin
                pending     <= 1'b0;
                shared_flag <= 1'b0;
                if (mode == RB_ECHO) echo_phase <= ~echo_phase;
            end
            if (wr_valid) begin
                shared_flag <= 1'b1;
                last_addr   <= wr_addr;
                last_data   <= wr_data;
            end
            if (sel_write) begin
                mode       <= new_mode;
                sel_reg    <= wr_data[ADDR_W-1:0];
                pending    <= (new_mode == RB_TWO_STAGE);
                echo_phase <= 1'b0;
            end
        end
    end

    // R4
    sel_load_chk: assert property (@(posedge clk) disable iff (rst)
        sel_write |=> (sel_reg == $past(wr_data[ADDR_W-1:0])));

    // R5
    two_stage_arm_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_write && new_mode == RB_TWO_STAGE) |=> pending);

    // R8
    shared_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_start && !wr_valid) |=> !shared_flag);

    // R9
    echo_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_start && !wr_valid && mode == RB_ECHO) |=> (echo_phase != $past(echo_phase)));

endmodule

// File: rtl/rb_frame_mux.sv
module rb_frame_mux
    import rb_pkg::*;
#(
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 5'h15,
    parameter logic [CRC_W-1:0]  CRC_POLY    = 8'h07
) (
    input  rb_mode_e           mode,
    input  logic               pending,
    input  logic               shared_flag,
    input  logic               echo_phase,
    input  logic [ADDR_W-1:0]  sel_reg,
    input  logic [DATA_W-1:0]  rd_data,
    input  logic [DATA_W-1:0]  status_word,
    input  logic               fault_in,
    input  logic [ADDR_W-1:0]  last_addr,
    input  logic [DATA_W-1:0]  last_data,
    input  logic               crc_en,
    output logic [FRAME_W-1:0] frame_word,
    output logic               frame_drive
);

    rb_src_e     src;
    rb_payload_t pay;

    always_comb begin
        src = SRC_NONE;
        unique case (mode)
            RB_TWO_STAGE: if (pending) src = SRC_REG;
            RB_STATUS:    src = SRC_STATUS;
            RB_SHARED:    if (shared_flag) src = SRC_STATUS;
            RB_ECHO:      src = echo_phase ? SRC_ECHO : SRC_STATUS;
            default:      src = SRC_NONE;
        endcase
    end

    always_comb begin
        pay.fault = fault_in;
        unique case (src)
            SRC_REG: begin
                pay.addr = sel_reg;
                pay.data = rd_data;
            end
            SRC_STATUS: begin
                pay.addr = STATUS_ADDR;
                pay.data = status_word;
            end
            SRC_ECHO: begin
                pay.addr = last_addr;
                pay.data = last_data;
            end
            default: begin
                pay.addr = '0;
                pay.data = '0;
            end
        endcase
    end

    assign frame_word  = build_frame(pay, crc_en, CRC_POLY);
    assign frame_drive = (src != SRC_NONE);

endmodule

// File: rtl/rb_shifter.sv
module rb_shifter
    import rb_pkg::*;
#(
    parameter bit IDLE_HIGH = 1'b0,
    parameter int W         = FRAME_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sync_n,
    input  logic         sclk,
    input  logic [W-1:0] frame_word,
    input  logic         frame_drive,
    output logic         frame_start,
    output logic         sdo,
    output logic         sdo_oe
);

    logic         sync_q;
    logic         sclk_q;
    logic         first_q;
    logic         oe_q;
    logic         launch;
    logic [W-1:0] sh_q;

    assign frame_start = sync_q & ~sync_n;
    assign launch      = sclk & ~sclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= 1'b1;
            sclk_q  <= IDLE_HIGH;
            first_q <= 1'b0;
            oe_q    <= 1'b0;
            sh_q    <= '0;
        end else begin
            sync_q <= sync_n;
            sclk_q <= sclk;
            if (frame_start) begin
                sh_q    <= frame_word;
                oe_q    <= frame_drive;
                first_q <= !IDLE_HIGH;
            end else if (sync_n) begin
                oe_q <= 1'b0;
            end else if (launch) begin
                if (first_q) first_q <= 1'b0;
                else         sh_q    <= {sh_q[W-2:0], 1'b0};
            end
        end
    end

    assign sdo    = sh_q[W-1];
    assign sdo_oe = oe_q;

    // R10
    release_chk: assert property (@(posedge clk) disable iff (rst)
        sync_n |=> !sdo_oe);

    // R10
    hold_between_edges_chk: assert property (@(posedge clk) disable iff (rst)
        (!frame_start && !launch) |=> $stable(sh_q));

endmodule

// File: rtl/rb_sdo_engine.sv
module rb_sdo_engine
    import rb_pkg::*;
#(
    parameter bit                IDLE_HIGH   = 1'b0,
    parameter logic [ADDR_W-1:0] SEL_ADDR    = 5'h13,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 5'h15,
    parameter logic [CRC_W-1:0]  CRC_POLY    = 8'h07
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_n,
    input  logic              sclk,
    input  logic              crc_en,
    input  logic              fault_in,
    input  logic [DATA_W-1:0] status_word,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              sdo,
    output logic              sdo_oe
);

    rb_mode_e           mode;
    logic [ADDR_W-1:0]  sel_reg;
    logic               pending;
    logic               shared_flag;
    logic               echo_phase;
    logic [ADDR_W-1:0]  last_addr;
    logic [DATA_W-1:0]  last_data;
    logic [FRAME_W-1:0] frame_word;
    logic               frame_drive;
    logic               frame_start;

    rb_select_regs #(.SEL_ADDR(SEL_ADDR)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_valid    (wr_valid),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .frame_start (frame_start),
        .mode        (mode),
        .sel_reg     (sel_reg),
        .pending     (pending),
        .shared_flag (shared_flag),
        .echo_phase  (echo_phase),
        .last_addr   (last_addr),
        .last_data   (last_data)
    );

    rb_frame_mux #(.STATUS_ADDR(STATUS_ADDR), .CRC_POLY(CRC_POLY)) u_mux (
        .mode        (mode),
        .pending     (pending),
        .shared_flag (shared_flag),
        .echo_phase  (echo_phase),
        .sel_reg     (sel_reg),
        .rd_data     (rd_data),
        .status_word (status_word),
        .fault_in    (fault_in),
        .last_addr   (last_addr),
        .last_data   (last_data),
        .crc_en      (crc_en),
        .frame_word  (frame_word),
        .frame_drive (frame_drive)
    );

    rb_shifter #(.IDLE_HIGH(IDLE_HIGH), .W(FRAME_W)) u_shift (
        .clk         (clk),
        .rst         (rst),
        .sync_n      (sync_n),
        .sclk        (sclk),
        .frame_word  (frame_word),
        .frame_drive (frame_drive),
        .frame_start (frame_start),
        .sdo         (sdo),
        .sdo_oe      (sdo_oe)
    );

    // R11
    assign rd_addr = sel_reg;

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> (!sdo_oe && rd_addr == '0));

endmodule

// File: tb/rb_sdo_engine_test.sv
`timescale 1ns/1ps
module rb_sdo_engine_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sync_n = 1'b1;
    logic        sclk = 1'b0;
    logic        crc_en = 1'b1;
    logic        fault_in = 1'b0;
    logic [15:0] status_word = 16'h1234;
    logic        wr_valid = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [4:0]  rd_addr;
    logic [15:0] rd_data;
    logic        sdo;
    logic        sdo_oe;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    rb_sdo_engine uut (
        .clk(clk), .rst(rst), .sync_n(sync_n), .sclk(sclk), .crc_en(crc_en),
        .fault_in(fault_in), .status_word(status_word), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .sdo(sdo), .sdo_oe(sdo_oe)
    );

    function automatic logic [15:0] regval(input logic [4:0] a);
        return (a == 5'h14) ? 16'hA000 : {3'b011, a, 3'b000, ~a};
    endfunction

    always_comb rd_data = regval(rd_addr);

    function automatic logic [7:0] ref_crc(input logic [23:0] w);
        logic [7:0] c = 8'h00;
        for (int i = 23; i >= 0; i--) begin
            if (c[7] ^ w[i]) c = {c[6:0], 1'b0} ^ 8'h07;
            else             c = {c[6:0], 1'b0};
        end
        return c;
    endfunction

    function automatic logic [31:0] mk(input logic f, input logic [4:0] a,
                                       input logic [15:0] d, input logic c);
        logic [23:0] h = {2'b10, f, a, d};
        return {h, (c ? ref_crc(h) : 8'h00)};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // kinds: 0 not driven, 1 selected register, 2 status, 3 echo
    typedef struct packed {
        logic        do_wr;
        logic [4:0]  waddr;
        logic [15:0] wdata;
        logic        crc_on;
        logic        flt;
        logic [1:0]  kind;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 5'h00, 16'h0000, 1'b1, 1'b0, 2'd0},   // R1 R5 idle two-stage
        '{1'b1, 5'h13, 16'h0014, 1'b1, 1'b0, 2'd1},   // R2 R4 R5
        '{1'b1, 5'h13, 16'h0005, 1'b1, 1'b1, 2'd1},   // R6
        '{1'b1, 5'h00, 16'h0000, 1'b1, 1'b0, 2'd0},   // R5 no select
        '{1'b1, 5'h13, 16'h000A, 1'b0, 1'b0, 2'd1},   // R3
        '{1'b1, 5'h13, 16'h0100, 1'b1, 1'b0, 2'd2},   // R7
        '{1'b0, 5'h00, 16'h0000, 1'b1, 1'b1, 2'd2},   // R7
        '{1'b1, 5'h13, 16'h0200, 1'b1, 1'b0, 2'd2},   // R8
        '{1'b0, 5'h00, 16'h0000, 1'b1, 1'b0, 2'd0},   // R8
        '{1'b1, 5'h02, 16'h1111, 1'b1, 1'b0, 2'd2},   // R8
        '{1'b0, 5'h00, 16'h0000, 1'b1, 1'b0, 2'd0},   // R8
        '{1'b1, 5'h13, 16'h0300, 1'b1, 1'b0, 2'd2},   // R9
        '{1'b1, 5'h05, 16'hBEEF, 1'b1, 1'b0, 2'd3},   // R9
        '{1'b0, 5'h00, 16'h0000, 1'b1, 1'b1, 2'd2},   // R9
        '{1'b0, 5'h00, 16'h0000, 1'b1, 1'b0, 2'd3},   // R9
        '{1'b1, 5'h13, 16'h0000, 1'b1, 1'b0, 2'd1}    // R4 R11
    };

    function automatic string tag_of(input int i);
        case (i)
            0:       return "R1";
            1:       return "R2";
            2:       return "R6";
            3:       return "R5";
            4:       return "R3";
            5, 6:    return "R7";
            7, 8, 9, 10: return "R8";
            15:      return "R4";
            default: return "R9";
        endcase
    endfunction

    task automatic do_write(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_frame(output logic [31:0] word, output bit oe_all, output bit oe_any);
        word = '0; oe_all = 1'b1; oe_any = 1'b0;
        @(negedge clk); sync_n = 1'b0;
        @(negedge clk); @(negedge clk);
        for (int b = 31; b >= 0; b--) begin
            sclk = 1'b1;
            @(negedge clk);
            word[b] = sdo;
            oe_all &= sdo_oe;
            oe_any |= sdo_oe;
            sclk = 1'b0;
            @(negedge clk);
        end
        sync_n = 1'b1;
        @(negedge clk); @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [4:0]  sel_m = 5'h00;
        logic [4:0]  la = 5'h00;
        logic [15:0] ld = 16'h0000;
        logic [31:0] w;
        logic [31:0] exp;
        bit          oa, on;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 R11 reset state
        check(!sdo_oe, "R1", {31'b0, sdo_oe}, 32'h0);
        check(rd_addr == 5'h00, "R11", {27'b0, rd_addr}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            crc_en   = VEC[i].crc_on;
            fault_in = VEC[i].flt;
            if (VEC[i].do_wr) begin
                do_write(VEC[i].waddr, VEC[i].wdata);
                la = VEC[i].waddr; ld = VEC[i].wdata;
                if (VEC[i].waddr == 5'h13) sel_m = VEC[i].wdata[4:0];
            end
            // R11 read address follows selection
            check(rd_addr == sel_m, "R11", {27'b0, rd_addr}, {27'b0, sel_m});
            run_frame(w, oa, on);
            // R10 released after chip select rises
            check(!sdo_oe, "R10", {31'b0, sdo_oe}, 32'h0);
            case (VEC[i].kind)
                2'd1: exp = mk(VEC[i].flt, sel_m, regval(sel_m), VEC[i].crc_on);
                2'd2: exp = mk(VEC[i].flt, 5'h15, status_word, VEC[i].crc_on);
                2'd3: exp = mk(VEC[i].flt, la, ld, VEC[i].crc_on);
                default: exp = '0;
            endcase
            if (VEC[i].kind == 2'd0) begin
                check(!on, tag_of(i), {31'b0, on}, 32'h0);
            end else begin
                check(oa, tag_of(i), {31'b0, oa}, 32'h1);
                check(w == exp, tag_of(i), w, exp);
            end
            if (i == 1) check(w == 32'h94A0001A, "R2", w, 32'h94A0001A);
            if (i == 4) check(w[31:30] == 2'b10 && w[7:0] == 8'h00, "R3", w, exp);
        end

        // R10 no bit shifts without a serial clock edge while selected
        do_write(5'h13, 16'h0100);
        @(negedge clk); sync_n = 1'b0;
        repeat (6) @(negedge clk);
        exp = mk(1'b0, 5'h15, status_word, 1'b1);
        check(sdo == exp[31] && sdo_oe, "R10", {30'b0, sdo_oe, sdo}, {30'b0, 1'b1, exp[31]});
        sclk = 1'b1; @(negedge clk); sclk = 1'b0; @(negedge clk);
        sclk = 1'b1; @(negedge clk);
        check(sdo == exp[30], "R10", {31'b0, sdo}, {31'b0, exp[30]});
        sclk = 1'b0;
        sync_n = 1'b1;
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule